// File: doc/BRIEF.md
# Page ECC Verdict Engine

This block runs once a page read has landed in one of the controller's page buffers. It decides whether the page is usable, and how many bits were repaired. Per-sector error counts arrive as packed 32-bit status words. The engine walks the sectors that belong to the selected buffer one per cycle. It sums the repaired bits and keeps the largest count seen in any single sector.

When a sector reports a count it cannot repair, the scan stops. The engine then reads the buffer RAM through a synchronous port to find out whether the page is simply erased. The main area is read word by word, followed by a programmable run of ECC byte positions in the spare area. An erased page is forgiven; any other page is flagged uncorrectable. A one-cycle `done` strobe marks the moment the verdict outputs are valid.

Top module: `page_ecc_verdict`

## Requirements
- R1: The count of sector n is bits [3:0] of byte lane (3 - n mod 4) of status word n/4, where lane k covers bits [8k+7:8k]. Sector 0 therefore sits in bits [27:24] of word 0. The upper nibble of each byte has no effect.
- R2: `start` samples `buf_sel` and `sect_cnt`. The sectors scanned are buf_sel*sect_cnt up to buf_sel*sect_cnt+sect_cnt-1. With sect_cnt = 0 the evaluation ends at once with all results zero.
- R3: Each count below 15 is added to `corrected_total`. `max_bitflips` holds the largest such count in the scanned range.
- R4: A count of 15 ends the scan. Counts of that sector and of every later sector are not added to the total or the maximum.
- R5: After a count of 15, `uncorrectable` stays 0 if two conditions hold: every main-area word of the buffer reads 0xFFFFFFFF, and every listed ECC byte reads 0xFF.
- R6: After a count of 15 on a page that fails the erased test of R5, `uncorrectable` is 1.
- R7: Buffer b occupies RAM words b*2*PAGE_WORDS onward. Its main area is PAGE_WORDS words, and its spare area follows directly. The listed spare bytes are ecc_pos_base up to ecc_pos_base+ecc_pos_len-1. Spare byte p lives in spare word p/4, bits [31-8*(p mod 4) -: 8]. Spare bytes outside the list have no effect.
- R8: An accepted `start` clears `corrected_total`, `max_bitflips` and `uncorrectable`. Results hold from `done` until the next accepted `start`.
- R9: `done` is high for exactly one cycle per evaluation. With no count of 15 it is high in the cycle after the (sect_cnt+1)-th rising edge, counting the edge that samples `start` as the first.
- R10: A `start` that arrives while an evaluation is running is ignored.
- R11: After reset, `done`, `uncorrectable`, `corrected_total`, `max_bitflips` and `ram_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation |
| buf_sel | input | BUF_W | Page buffer index |
| sect_cnt | input | SPP_W | Sectors per page |
| ecc_pos_base | input | PB_W | First listed ECC byte in the spare area |
| ecc_pos_len | input | PL_W | Number of listed ECC bytes |
| stat_words | input | STAT_WORDS*32 | Packed sector error counts, word 0 in the low 32 bits |
| ram_rd_en | output | 1 | Buffer RAM read strobe |
| ram_addr | output | AW | Buffer RAM word address |
| ram_rdata | input | 32 | Read data, valid one cycle after the strobe |
| done | output | 1 | Verdict valid pulse |
| uncorrectable | output | 1 | Page has an unrepairable, non-erased sector |
| corrected_total | output | TOT_W | Sum of repaired bits |
| max_bitflips | output | 4 | Largest repaired count in any sector |

## Verification
Directed status words with a distinct count in each byte lane separate the correct lane order from a reversed one. Running the same status against several buffer indices shows that the sector window moves with the buffer.

Pages that are fully erased are set against pages with one bad main-area word, a bad listed ECC byte, or a bad unlisted spare byte. This tells forgiveness apart from flagging and shows the ECC list bounds.

Random status words, which sometimes contain a 15 at any position, and random single-word damage anywhere in the RAM check the early stop and the buffer addressing. A start pulse sent during the blank walk, and a run after a large maximum, show that busy starts are ignored and that results are cleared.

// File: rtl/pes_pkg.sv
package pes_pkg;
    localparam logic [3:0]  UNCORR_CODE = 4'hF;
    localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {EV_IDLE, EV_SCAN, EV_WAIT} ev_state_e;
    typedef enum logic [1:0] {BW_IDLE, BW_MAIN, BW_SPARE, BW_DRAIN} bw_state_e;
endpackage

// File: rtl/pes_sector_pick.sv
module pes_sector_pick #(
    parameter int MAX_SECTORS = 16,
    parameter int SEC_W       = 7
) (
    input  logic [MAX_SECTORS*8-1:0] stat_i,
    input  logic [SEC_W-1:0]         sector_i,
    output logic [3:0]               count_o
);
    localparam int SI_W = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1;

    logic [3:0] cnt_arr [MAX_SECTORS];
    logic [MAX_SECTORS-1:0] hi_par;
    logic unused_hi_nibbles;

    // Sector g: word g/4, byte lane 3 - g%4 (first sector in the top byte)
    for (genvar g = 0; g < MAX_SECTORS; g++) begin : g_lane
        localparam int LSB = (g / 4) * 32 + (3 - (g % 4)) * 8;
        assign cnt_arr[g] = stat_i[LSB +: 4];
        assign hi_par[g]  = ^stat_i[LSB + 4 +: 4];
    end
    assign unused_hi_nibbles = ^hi_par;

    always_comb begin
        if (32'(sector_i) < MAX_SECTORS) count_o = cnt_arr[sector_i[SI_W-1:0]];
        else                              count_o = '0;
    end
endmodule

// File: rtl/pes_blank_walk.sv
module pes_blank_walk
    import pes_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int NUM_BUFS   = 4,
    localparam int BUF_W       = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int RAM_WORDS   = NUM_BUFS * 2 * PAGE_WORDS,
    localparam int AW          = $clog2(RAM_WORDS),
    localparam int SPARE_BYTES = 4 * PAGE_WORDS,
    localparam int PB_W        = $clog2(SPARE_BYTES),
    localparam int PL_W        = PB_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [BUF_W-1:0] buf_i,
    input  logic [PB_W-1:0]  pos_base_i,
    input  logic [PL_W-1:0]  pos_len_i,
    output logic             ram_rd_en_o,
    output logic [AW-1:0]    ram_addr_o,
    input  logic [31:0]      ram_rdata_i,
    output logic             done_o,
    output logic             blank_o
);
    localparam int IW = PL_W;
    localparam logic [AW-1:0] BUF_STRIDE = AW'(2 * PAGE_WORDS);
    localparam logic [AW-1:0] SPARE_OFS  = AW'(PAGE_WORDS);
    localparam logic [IW-1:0] LAST_MAIN  = IW'(PAGE_WORDS - 1);

    typedef struct packed {
        bw_state_e        st;
        logic [AW-1:0]    base;
        logic [IW-1:0]    idx;
        logic [PB_W-1:0]  pbase;
        logic [PL_W-1:0]  plen;
        logic             pend;
        logic             pend_byte;
        logic [1:0]       lane;
        logic             fail;
        logic             done;
        logic             blank;
    } bw_regs_t;

    bw_regs_t q, d;
    logic            mism, fail_now;
    logic [PL_W-1:0] pos;
    logic [4:0]      lane_sh;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.pend      = 1'b0;
        ram_rd_en_o = 1'b0;
        ram_addr_o  = '0;
        lane_sh     = {~q.lane, 3'b000};
        mism        = 1'b0;
        if (q.pend) begin
            if (q.pend_byte) mism = (ram_rdata_i[lane_sh +: 8] != ERASED_BYTE);
            else             mism = (ram_rdata_i != ERASED_WORD);
        end
        fail_now = q.fail | mism;
        d.fail   = fail_now;
        pos      = PL_W'(q.pbase) + q.idx;

        unique case (q.st)
            BW_IDLE: begin
                if (go_i) begin
                    d.st    = BW_MAIN;
                    d.base  = AW'(buf_i) * BUF_STRIDE;
                    d.idx   = '0;
                    d.fail  = 1'b0;
                    d.pbase = pos_base_i;
                    d.plen  = pos_len_i;
                end
            end
            BW_MAIN: begin
                ram_rd_en_o = 1'b1;
                ram_addr_o  = q.base + AW'(q.idx);
                d.pend      = 1'b1;
                d.pend_byte = 1'b0;
                if (q.idx == LAST_MAIN) begin
                    d.idx = '0;
                    d.st  = (q.plen == '0) ? BW_DRAIN : BW_SPARE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            BW_SPARE: begin
                ram_rd_en_o = 1'b1;
                ram_addr_o  = q.base + SPARE_OFS + AW'(pos >> 2);
                d.pend      = 1'b1;
                d.pend_byte = 1'b1;
                d.lane      = pos[1:0];
                if (q.idx == q.plen - 1'b1) d.st  = BW_DRAIN;
                else                        d.idx = q.idx + 1'b1;
            end
            default: begin
                d.done  = 1'b1;
                d.blank = ~fail_now;
                d.st    = BW_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= BW_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o  = q.done;
    assign blank_o = q.blank;

    // R7: every read stays inside the selected buffer (main plus spare)
    a_r7_read_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en_o |-> (({1'b0, ram_addr_o} >= {1'b0, q.base}) &&
                         ({1'b0, ram_addr_o} < ({1'b0, q.base} + (AW+1)'(2 * PAGE_WORDS)))));

    // R9: walk completion is a single-cycle strobe
    a_r9_walk_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/page_ecc_verdict.sv
module page_ecc_verdict
    import pes_pkg::*;
#(
    parameter int PAGE_WORDS  = 16,
    parameter int NUM_BUFS    = 4,
    parameter int MAX_SECTORS = 16,
    localparam int BUF_W       = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int SPP_W       = $clog2(MAX_SECTORS) + 1,
    localparam int SEC_W       = BUF_W + SPP_W,
    localparam int STAT_WORDS  = (MAX_SECTORS + 3) / 4,
    localparam int RAM_WORDS   = NUM_BUFS * 2 * PAGE_WORDS,
    localparam int AW          = $clog2(RAM_WORDS),
    localparam int SPARE_BYTES = 4 * PAGE_WORDS,
    localparam int PB_W        = $clog2(SPARE_BYTES),
    localparam int PL_W        = PB_W + 1,
    localparam int TOT_W       = $clog2(14 * MAX_SECTORS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BUF_W-1:0]        buf_sel,
    input  logic [SPP_W-1:0]        sect_cnt,
    input  logic [PB_W-1:0]         ecc_pos_base,
    input  logic [PL_W-1:0]         ecc_pos_len,
    input  logic [STAT_WORDS*32-1:0] stat_words,
    output logic                    ram_rd_en,
    output logic [AW-1:0]           ram_addr,
    input  logic [31:0]             ram_rdata,
    output logic                    done,
    output logic                    uncorrectable,
    output logic [TOT_W-1:0]        corrected_total,
    output logic [3:0]              max_bitflips
);
    typedef struct packed {
        ev_state_e        st;
        logic [BUF_W-1:0] bsel;
        logic [SEC_W-1:0] sector;
        logic [SPP_W-1:0] left;
        logic [TOT_W-1:0] total;
        logic [3:0]       maxf;
        logic             uncorr;
        logic             done;
    } ev_regs_t;

    ev_regs_t q, d;
    logic [3:0] cnt;
    logic       walk_go, walk_done, walk_blank;

    pes_sector_pick #(
        .MAX_SECTORS (MAX_SECTORS),
        .SEC_W       (SEC_W)
    ) i_pick (
        .stat_i   (stat_words[MAX_SECTORS*8-1:0]),
        .sector_i (q.sector),
        .count_o  (cnt)
    );

    if (STAT_WORDS * 32 > MAX_SECTORS * 8) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^stat_words[STAT_WORDS*32-1:MAX_SECTORS*8];
    end

    pes_blank_walk #(
        .PAGE_WORDS (PAGE_WORDS),
        .NUM_BUFS   (NUM_BUFS)
    ) i_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (walk_go),
        .buf_i       (q.bsel),
        .pos_base_i  (ecc_pos_base),
        .pos_len_i   (ecc_pos_len),
        .ram_rd_en_o (ram_rd_en),
        .ram_addr_o  (ram_addr),
        .ram_rdata_i (ram_rdata),
        .done_o      (walk_done),
        .blank_o     (walk_blank)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        walk_go = 1'b0;
        unique case (q.st)
            EV_IDLE: begin
                if (start) begin
                    d.bsel   = buf_sel;
                    d.sector = SEC_W'(buf_sel) * SEC_W'(sect_cnt);
                    d.left   = sect_cnt;
                    d.total  = '0;
                    d.maxf   = '0;
                    d.uncorr = 1'b0;
                    if (sect_cnt == '0) d.done = 1'b1;
                    else                d.st   = EV_SCAN;
                end
            end
            EV_SCAN: begin
                if (cnt == UNCORR_CODE) begin
                    walk_go = 1'b1;
                    d.st    = EV_WAIT;
                end else begin
                    d.total = q.total + TOT_W'(cnt);
                    if (cnt > q.maxf) d.maxf = cnt;
                    if (q.left == SPP_W'(1)) begin
                        d.done = 1'b1;
                        d.st   = EV_IDLE;
                    end else begin
                        d.left   = q.left - 1'b1;
                        d.sector = q.sector + 1'b1;
                    end
                end
            end
            default: begin
                if (walk_done) begin
                    d.uncorr = ~walk_blank;
                    d.done   = 1'b1;
                    d.st     = EV_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= EV_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done            = q.done;
    assign uncorrectable   = q.uncorr;
    assign corrected_total = q.total;
    assign max_bitflips    = q.maxf;

    // R9: verdict strobe lasts one cycle
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an accepted start leaves cleared results behind
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == EV_IDLE && start) |=> (corrected_total == '0 && max_bitflips == '0 && !uncorrectable));

    // R4: once the blank walk runs, the accumulators are frozen
    a_r4_frozen_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == EV_WAIT) |=> ($stable(corrected_total) && $stable(max_bitflips)));

    // R3: the maximum is only ever a repairable count
    a_r3_max_repairable: assert property (@(posedge clk) disable iff (!rst_n)
        max_bitflips != UNCORR_CODE);

    // R10: the RAM is only read while a walk runs, never while idle
    a_r10_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == EV_IDLE) |-> !ram_rd_en);
endmodule

// File: tb/test_page_ecc_verdict.sv
module test_page_ecc_verdict;
    localparam int PAGE_WORDS  = 16;
    localparam int NUM_BUFS    = 4;
    localparam int MAX_SECTORS = 16;
    localparam int BUF_W       = 2;
    localparam int SPP_W       = 5;
    localparam int STAT_WORDS  = 4;
    localparam int RAM_WORDS   = NUM_BUFS * 2 * PAGE_WORDS;
    localparam int AW          = 7;
    localparam int PB_W        = 6;
    localparam int PL_W        = 7;
    localparam int TOT_W       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BUF_W-1:0] buf_sel = '0;
    logic [SPP_W-1:0] sect_cnt = '0;
    logic [PB_W-1:0]  ecc_pos_base = '0;
    logic [PL_W-1:0]  ecc_pos_len = '0;
    logic [STAT_WORDS*32-1:0] stat_words = '0;
    logic             ram_rd_en;
    logic [AW-1:0]    ram_addr;
    logic [31:0]      ram_rdata = '0;
    logic             done, uncorrectable;
    logic [TOT_W-1:0] corrected_total;
    logic [3:0]       max_bitflips;

    logic [31:0] mem [RAM_WORDS];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr];

    page_ecc_verdict i_page_ecc_verdict (
        .clk, .rst_n, .start, .buf_sel, .sect_cnt, .ecc_pos_base, .ecc_pos_len,
        .stat_words, .ram_rd_en, .ram_addr, .ram_rdata, .done, .uncorrectable,
        .corrected_total, .max_bitflips
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_cnt(input int s);
        return int'(stat_words[(s / 4) * 32 + (3 - s % 4) * 8 +: 4]);
    endfunction

    function automatic bit ref_blank(input int b);
        int base = b * 2 * PAGE_WORDS;
        for (int i = 0; i < PAGE_WORDS; i++)
            if (mem[base + i] != 32'hFFFF_FFFF) return 1'b0;
        for (int j = 0; j < int'(ecc_pos_len); j++) begin
            int p = int'(ecc_pos_base) + j;
            logic [31:0] w = mem[base + PAGE_WORDS + p / 4];
            if (w[31 - 8 * (p % 4) -: 8] != 8'hFF) return 1'b0;
        end
        return 1'b1;
    endfunction

    int e_unc, e_tot, e_max, e_hit;
    task automatic ref_eval(input int b, input int spp);
        e_unc = 0; e_tot = 0; e_max = 0; e_hit = 0;
        for (int s = b * spp; s < b * spp + spp; s++) begin
            int c = ref_cnt(s);
            if (c == 15) begin
                e_hit = 1;
                e_unc = ref_blank(b) ? 0 : 1;
                break;
            end
            e_tot += c;
            if (c > e_max) e_max = c;
        end
    endtask

    int r_unc, r_tot, r_max;
    task automatic run_eval(input string tag, input int b, input int spp, input bit poke);
        int n;
        ref_eval(b, spp);
        @(negedge clk);
        buf_sel = BUF_W'(b); sect_cnt = SPP_W'(spp); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin start = 1'b1; buf_sel = BUF_W'(b ^ 1); sect_cnt = 5'd1; end
            if (poke && n == 4) begin start = 1'b0; buf_sel = BUF_W'(b); end
        end
        chk({tag, " R9 done seen"}, int'(done), 1);
        r_unc = int'(uncorrectable); r_tot = int'(corrected_total); r_max = int'(max_bitflips);
        chk({tag, " R5 R6 uncorrectable"}, r_unc, e_unc);
        chk({tag, " R3 R4 corrected_total"}, r_tot, e_tot);
        chk({tag, " R3 R8 max_bitflips"}, r_max, e_max);
        if (!e_hit) chk({tag, " R9 latency"}, n, spp + 1);
        @(negedge clk);
        chk({tag, " R9 single cycle"}, int'(done), 0);
        if (poke) begin
            int extra = 0;
            repeat (40) begin @(negedge clk); if (done) extra++; end
            chk({tag, " R10 busy start ignored"}, extra, 0);
        end
    endtask

    task automatic erase_all();
        for (int i = 0; i < RAM_WORDS; i++) mem[i] = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        erase_all();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 done", int'(done), 0);
        chk("R11 uncorrectable", int'(uncorrectable), 0);
        chk("R11 total", int'(corrected_total), 0);
        chk("R11 max", int'(max_bitflips), 0);
        chk("R11 rd_en", int'(ram_rd_en), 0);
        rst_n = 1'b1;
        ecc_pos_base = 6'd8; ecc_pos_len = 7'd8;

        // R1: lane order, high nibbles ignored
        stat_words = '0;
        stat_words[31:0]  = 32'hA1B2_C3D4;
        stat_words[63:32] = 32'h5906_0000;
        run_eval("R1 lanes b0", 0, 2, 1'b0);
        chk("R1 explicit total", r_tot, 3);
        chk("R1 explicit max", r_max, 2);
        run_eval("R1 lanes b1", 1, 2, 1'b0);
        chk("R2 explicit total", r_tot, 7);
        run_eval("R2 window b2", 2, 2, 1'b0);
        chk("R2 explicit max", r_max, 9);
        run_eval("R2 zero sectors", 3, 0, 1'b0);

        // R4 R5: uncorrectable mid-page on blank buffer
        stat_words = '0;
        stat_words[31:0] = 32'h050F_0700;
        run_eval("R4 stop blank", 0, 3, 1'b0);
        chk("R4 explicit total", r_tot, 5);
        chk("R5 explicit forgiven", r_unc, 0);
        // R6: damaged main word
        mem[PAGE_WORDS - 1] = 32'hFFFF_FFFE;
        run_eval("R6 main damage", 0, 3, 1'b0);
        chk("R6 explicit flagged", r_unc, 1);
        erase_all();
        // R7: listed ECC byte 10 -> spare word 2, bits [15:8]
        mem[PAGE_WORDS + 2] = 32'hFFFF_00FF;
        run_eval("R7 listed byte", 0, 3, 1'b0);
        chk("R7 explicit listed", r_unc, 1);
        erase_all();
        // R7: unlisted byte 16 -> spare word 4, bits [31:24]
        mem[PAGE_WORDS + 4] = 32'h00FF_FFFF;
        run_eval("R7 unlisted byte", 0, 3, 1'b0);
        chk("R7 explicit unlisted", r_unc, 0);
        // R10: start during walk ignored
        run_eval("R10 busy", 0, 3, 1'b1);
        erase_all();

        // R8: large max then all-zero page
        stat_words = '0;
        stat_words[31:0] = 32'h0E00_0000;
        run_eval("R8 big", 0, 1, 1'b0);
        stat_words = '0;
        run_eval("R8 cleared", 0, 1, 1'b0);
        chk("R8 explicit max cleared", r_max, 0);

        // Random mix
        for (int t = 0; t < 300; t++) begin
            int b = $urandom % 4;
            int spp = (t % 37 == 0) ? 0 : 1 + $urandom % 4;
            int kind = $urandom % 4;
            int base = b * 2 * PAGE_WORDS;
            erase_all();
            for (int s = 0; s < MAX_SECTORS; s++) begin
                int lo = ($urandom % 8 == 0) ? 15 : $urandom % 15;
                stat_words[(s / 4) * 32 + (3 - s % 4) * 8 +: 8] = {4'($urandom), 4'(lo)};
            end
            ecc_pos_base = PB_W'($urandom % 48);
            ecc_pos_len  = PL_W'($urandom % 17);
            if (kind == 1) mem[base + $urandom % PAGE_WORDS] = $urandom & 32'hFFFF_FFFE;
            if (kind == 2) begin
                int p = $urandom % 64;
                mem[base + PAGE_WORDS + p / 4][31 - 8 * (p % 4) -: 8] = 8'h00;
            end
            if (kind == 3) mem[$urandom % RAM_WORDS] = 32'h0;
            run_eval("RAND R2 R3 R4 R5 R6 R7", b, spp, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule